// File: doc/BRIEF.md
# Register-Exchange Viterbi Decoder

This block decodes a hard-decision stream of a rate 1/2, constraint length 5 convolutional code. Each accepted input is one received pair of code bits. A single step updates all 16 trellis states at once. Sixteen add-compare-select units run side by side. They are wired so that states 2j and 2j+1 feed states j and j+8. Each state carries its own 32-bit survivor register of decided input bits. On every step, every survivor register is overwritten by the register of the predecessor that was chosen, shifted by one place, with the new decision bit entering at the bottom. No traceback pass follows.

Decisions leave the decoder from the state whose path metric is lowest, one bit per step, once the survivor registers are full. A flush pulse ends a block. The decoder then runs steps with a zero input and no received pair. The first four of these steps force the path back to state 0, and the rest empty the survivor register. The flush is complete when exactly as many bits have left the decoder as pairs were accepted. The decoder then returns to its reset condition, ready for the next block.

Top module: `rex_viterbi`

## Requirements
- R1: The code uses the generators 10011 and 11101 in binary (23 and 35 in octal). The window is {u, s[3:0]}, where u is the new input bit and s[3] is the newest previous bit. in_bits[0] is the parity of the window ANDed with 10011, and in_bits[1] is the parity of the window ANDed with 11101. For an error-free stream, the decoded bits equal the encoded data bits, in order.
- R2: The branch metric is the Hamming distance between the received pair and the pair expected on a transition. When the two paths into a state have equal metrics, the lower-numbered predecessor wins. Isolated single-bit channel errors, spaced well apart, are corrected.
- R3: Path metrics are 8 bits wide. When the smallest metric is 128 or more, that smallest metric is subtracted from every sum before it is stored. Streams of thousands of steps, including periodic errors, decode without wraparound.
- R4: After reset, in_ready is 1 and out_valid is 0. State 0 starts with metric 0, and all other states start at 255.
- R5: out_valid stays 0 until 32 pairs have been accepted. The first decoded bit (data bit 0) is valid in the cycle after the 33rd pair is accepted.
- R6: At most one decoded bit is produced per trellis step. Bits leave in data order, from the state that has the smallest new metric.
- R7: A flush runs steps with a zero input. It ends once the number of bits output equals the number of pairs accepted, and this also holds for blocks shorter than the survivor depth.
- R8: While a flush is running, in_ready is 0 and in_valid has no effect.
- R9: When a flush finishes, the decoder returns to its reset condition. The next block decodes on its own, starting again from state 0.
- R10: If flush and an accepted pair arrive in the same cycle, the pair is decoded as the final step of the block.
- R11: Idle cycles between accepted pairs do not change the decoded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A received pair is offered |
| in_ready | output | 1 | Decoder can take a pair (low during a flush) |
| in_bits | input | 2 | Received hard bits: [0] for generator 10011, [1] for generator 11101 |
| flush | input | 1 | One-cycle pulse that ends the current block |
| out_valid | output | 1 | out_bit holds a decoded bit |
| out_bit | output | 1 | Decoded data bit |

## Verification
The bench sweeps block lengths on both sides of the survivor depth and several data patterns, with and without idle gaps and isolated channel errors. It compares every decoded bit with the data that was encoded.

It targets the following failure modes:
- A wrong shuffle wiring or generator tap scrambles even error-free blocks.
- A broken metric or tie rule lets an injected error get through.
- Missing normalisation wraps the metrics on the 3000-step block and derails the decoder.
- A miscounted fill or drain shows up as a first output on the wrong acceptance, or as a bit count that differs from the block length.
- A decoder that takes garbage during a flush, or that does not restart cleanly, corrupts the block that follows.

// File: rtl/rex_viterbi.sv
module rex_viterbi #(
  parameter int DEPTH = 32,
  parameter int MW    = 8,
  parameter int CW    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_bits,
  input  logic       flush,
  output logic       out_valid,
  output logic       out_bit
);
  localparam int            NS   = 16;
  localparam int            FW   = $clog2(DEPTH + 1);
  localparam logic [4:0]    G0   = 5'b10011;
  localparam logic [4:0]    G1   = 5'b11101;
  localparam logic [MW-1:0] MAXM = {MW{1'b1}};
  localparam logic [MW-1:0] HALF = MW'(1 << (MW - 1));

  logic [MW-1:0]    pm   [NS];
  logic [DEPTH-1:0] sv   [NS];
  logic [MW-1:0]    nm   [NS];
  logic [DEPTH-1:0] nsv  [NS];
  logic             drop [NS];
  logic             flushing;
  logic [CW-1:0]    n_in, n_out, n_in_next;
  logic [FW-1:0]    fill;
  logic [MW-1:0]    pm_min, sub, bmin;
  logic [3:0]       best;
  logic             data_step, zero_step, step, done, emit, fill_done;

  function automatic logic [1:0] bmet(input logic [3:0] p, input logic u, input logic [1:0] r);
    logic [4:0] w;
    w = {u, p};
    return {1'b0, (^(w & G0)) ^ r[0]} + {1'b0, (^(w & G1)) ^ r[1]};
  endfunction

  function automatic logic [MW-1:0] clampm(input logic [MW:0] s);
    return s[MW] ? MAXM : s[MW-1:0];
  endfunction

  assign in_ready  = !flushing;
  assign data_step = in_valid && !flushing;
  assign done      = flushing && (n_out == n_in);
  assign zero_step = flushing && !done;
  assign step      = data_step || zero_step;
  assign fill_done = (fill == FW'(DEPTH));
  assign n_in_next = n_in + CW'(data_step);
  assign sub       = (pm_min >= HALF) ? pm_min : '0;
  assign emit      = step && fill_done && (n_out != n_in_next);

  always_comb begin
    pm_min = pm[0];
    for (int i = 1; i < NS; i++)
      if (pm[i] < pm_min) pm_min = pm[i];
  end

  for (genvar n = 0; n < NS; n++) begin : g_acs
    localparam logic [3:0] PA = 4'(2 * (n % 8));
    localparam logic [3:0] PB = 4'(2 * (n % 8) + 1);
    localparam logic       U  = 1'(n / 8);
    logic [1:0]  bma, bmb;
    logic [MW:0] sa, sb;
    logic        pick_b;
    assign bma    = zero_step ? 2'd0 : bmet(PA, U, in_bits);
    assign bmb    = zero_step ? 2'd0 : bmet(PB, U, in_bits);
    assign sa     = {1'b0, pm[PA]} + {{(MW-1){1'b0}}, bma} - {1'b0, sub};
    assign sb     = {1'b0, pm[PB]} + {{(MW-1){1'b0}}, bmb} - {1'b0, sub};
    assign pick_b = sb < sa;
    assign nm[n]  = (zero_step && U) ? MAXM : clampm(pick_b ? sb : sa);
    assign nsv[n] = {pick_b ? sv[PB][DEPTH-2:0] : sv[PA][DEPTH-2:0], U};
    assign drop[n] = pick_b ? sv[PB][DEPTH-1] : sv[PA][DEPTH-1];
  end

  always_comb begin
    best = '0;
    bmin = nm[0];
    for (int i = 1; i < NS; i++)
      if (nm[i] < bmin) begin
        bmin = nm[i];
        best = 4'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        pm[i] <= (i == 0) ? '0 : MAXM;
        sv[i] <= '0;
      end
      flushing  <= 1'b0;
      n_in      <= '0;
      n_out     <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (done) begin
      for (int i = 0; i < NS; i++) begin
        pm[i] <= (i == 0) ? '0 : MAXM;
        sv[i] <= '0;
      end
      flushing  <= 1'b0;
      n_in      <= '0;
      n_out     <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_bit <= drop[best];
        n_out   <= n_out + 1'b1;
      end
      if (step) begin
        for (int i = 0; i < NS; i++) begin
          pm[i] <= nm[i];
          sv[i] <= nsv[i];
        end
        if (!fill_done) fill <= fill + 1'b1;
      end
      n_in <= n_in_next;
      if (!flushing && flush) flushing <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pm_min <= HALF + 1'b1);  // R3
  AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> fill_done);  // R5
  AST_ONE_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(step));  // R6
  AST_DRAIN_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flushing) |-> $past(n_out == n_in));  // R7
  AST_FLUSH_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_step && in_valid) |=> $stable(n_in));  // R8
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flushing) |-> (pm[0] == '0 && pm[1] == MAXM && n_in == '0 && !out_valid));  // R9
endmodule

// File: tb/test_rex_viterbi.sv
module test_rex_viterbi;
  localparam int TCLK = 10;
  localparam int DEP  = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, flush = 1'b0;
  logic [1:0] in_bits = 2'b00;
  logic in_ready, out_valid, out_bit;

  int checks = 0, errors = 0, cycles = 0;
  int acc = 0, rx_n = 0, blk_n = 0;
  bit fl_started = 1'b0;
  bit data [0:4095];
  bit rx   [0:4095];
  logic [15:0] lfsr = 16'hACE1;

  rex_viterbi i_rex_viterbi (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .flush(flush), .out_valid(out_valid), .out_bit(out_bit));

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rx_n == 0 && !fl_started)  // R5: first bit right after the 33rd pair
        chk(acc == DEP + 1, "R5 first output timing", acc, DEP + 1);
      if (!fl_started)
        chk(acc > DEP, "R5 no early output", acc, DEP + 1);
      if (rx_n < 4096) rx[rx_n] = out_bit;
      rx_n++;
    end
  end

  function automatic logic [1:0] enc(input logic [3:0] s, input bit u);
    logic [4:0] w;
    w = {u, s};
    return {^(w & 5'b11101), ^(w & 5'b10011)};
  endfunction

  task automatic put(input logic [1:0] pr, input bit with_flush);
    bit rdy;
    in_valid = 1'b1;
    in_bits  = pr;
    flush    = with_flush;
    if (with_flush) fl_started = 1'b1;
    do begin
      @(negedge clk);
      rdy = in_ready;
      @(posedge clk);
      #1;
    end while (!rdy);
    in_valid = 1'b0;
    flush    = 1'b0;
    acc++;
  endtask

  // pat: 0 random, 1 zeros, 2 ones, 3 alternating
  task automatic run_block(input int n, input int pat, input int err_per, input bit gaps,
                           input bit garbage, input bit fl_last, input string tag);
    logic [3:0] s = 4'd0;
    logic [1:0] pr;
    bit first = 1'b1;
    acc = 0; rx_n = 0; blk_n = n; fl_started = 1'b0;
    for (int i = 0; i < n; i++) begin
      case (pat)
        0: begin lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; data[i] = lfsr[0]; end
        1: data[i] = 1'b0;
        2: data[i] = 1'b1;
        default: data[i] = 1'(i % 2);
      endcase
      pr = enc(s, data[i]);
      s  = {data[i], s[3:1]};
      if (err_per > 0 && i >= 10 && i < n - 40 && (i % err_per) == 0)
        pr[i % 2] = ~pr[i % 2];
      if (gaps && (i % 3) == 1) begin
        @(posedge clk);
        #1;
      end
      put(pr, fl_last && (i == n - 1));
    end
    if (!(fl_last && n > 0)) begin
      flush = 1'b1;
      fl_started = 1'b1;
      @(posedge clk);
      #1;
      flush = 1'b0;
    end
    while (1) begin
      if (garbage) begin
        in_valid = 1'b1;
        in_bits  = 2'(cycles);
      end
      @(negedge clk);
      if (in_ready) begin
        in_valid = 1'b0;
        break;
      end
      if (garbage && first) chk(in_ready == 1'b0, {tag, " R8 in_ready low in flush"}, in_ready, 0);
      first = 1'b0;
      @(posedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    chk(rx_n == n, {tag, " R7 output count"}, rx_n, n);
    for (int i = 0; i < n && i < rx_n; i++)
      if (rx[i] != data[i]) chk(1'b0, $sformatf("%s R1 bit %0d", tag, i), rx[i], data[i]);
    chk(1'b1, {tag, " R1 R6 ordered bits compared"}, 0, 0);
  endtask

  initial begin
    #(3 * TCLK);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R4 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R4 out_valid after reset", out_valid, 0);
    @(posedge clk);
    #1;
    run_block(64,   0, 0,  0, 0, 0, "R1 random");
    run_block(40,   1, 0,  0, 0, 0, "R1 zeros");
    run_block(40,   2, 0,  0, 0, 0, "R1 ones");
    run_block(50,   3, 0,  0, 0, 0, "R1 alternating");
    run_block(120,  0, 17, 0, 0, 0, "R2 single errors");
    run_block(5,    0, 0,  0, 0, 0, "R7 short block");
    run_block(32,   0, 0,  0, 0, 0, "R7 depth block");
    run_block(1,    2, 0,  0, 0, 0, "R7 one bit");
    run_block(0,    0, 0,  0, 0, 0, "R7 empty");
    run_block(80,   0, 0,  0, 1, 0, "R8 garbage in flush");
    run_block(70,   2, 0,  0, 0, 0, "R9 restart after garbage");
    run_block(60,   0, 0,  0, 0, 1, "R10 flush with last");
    run_block(90,   0, 13, 1, 0, 0, "R11 gaps");
    run_block(3000, 0, 16, 0, 0, 0, "R3 long with errors");
    run_block(48,   0, 0,  0, 0, 0, "R9 after long");
    finish_run();
  end
endmodule